// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers 48 level-sensitive interrupt request lines and reduces them to one interrupt request towards the processor, plus a vector byte that identifies which source won. Each line passes through its own enable bit. Among the lines that are both high and enabled, the one with the largest index wins. The vector byte is a fixed base of 10h plus the winning index.

Software programs the per-source enables through a small register port, and can also read the live vector there. The processor drives two global enable inputs, which mirror its status bits; the request to the processor is raised only when both are set. When the processor starts an acknowledge read, it pulses the acknowledge strobe. The vector is captured on that edge and held until the next acknowledge. If the winning line has dropped before the strobe, the captured byte is 10h, so software can recognise a request that went away.

Top module: `prio_vec_intc`

## Requirements
- R1: Among sources whose input is high and whose enable bit is set, the source with the highest index wins; priority is fixed, with index 47 highest and index 0 lowest.
- R2: Requests are level-sensitive: a source counts only while its input is high, and lowering it removes it from selection in the same cycle, with no memory of past pulses.
- R3: Register address 0 holds the enables of sources 0 to 31 in bits 31:0, and address 1 holds the enables of sources 32 to 47 in bits 15:0. Bits 31:16 at address 1 read as zero and ignore writes. Both enable words reset to zero, and a write takes effect at the clock edge that accepts it.
- R4: `cpu_irq` is high exactly when at least one enabled source is pending and both `gie_a` and `gie_b` are high.
- R5: Reading address 2 returns, in bits 7:0, 10h plus the index of the current winner, or 10h when no enabled source is pending. Bits 31:8 are zero. This value does not depend on the global enables.
- R6: Input 0 is treated as unconnected: `irq_in[0]` never counts as pending, whatever its enable bit.
- R7: At each rising edge where `ack_stb` is high, `vec_byte` takes the vector value from R5. It keeps that value until the next such edge, and it resets to 10h.
- R8: If the winning request is lowered before the acknowledge edge and no other enabled source is pending, the captured `vec_byte` is 10h.
- R9: Address 3 reads as zero. Writes to addresses 2 and 3 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 48 | Level-sensitive request lines, bit i is source i |
| gie_a | input | 1 | First global enable from processor status |
| gie_b | input | 1 | Second global enable from processor status |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 enables low, 1 enables high, 2 vector, 3 reserved) |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, combinational from `addr` |
| ack_stb | input | 1 | Acknowledge strobe, samples the vector |
| cpu_irq | output | 1 | Interrupt request to the processor |
| vec_byte | output | 8 | Vector captured at the last acknowledge |

## Verification
The hardest case to reach from the ports is a request that vanishes between the point where the processor sees `cpu_irq` and the acknowledge edge. It is hard because the winner has to be lowered in the same cycle that the strobe is sampled. A directed sequence raises one enabled source and confirms its vector. It then lowers that line in the same cycle that it raises `ack_stb`, and expects 10h. Random sparse request patterns and random enable words, with a fixed seed, cover the priority order, the masking, source 0 and the global gate; a bench function computes the expected vectors.

// File: rtl/intc_pkg.sv
package intc_pkg;

   typedef enum logic [1:0] {
      REG_EN_LO = 2'd0,
      REG_EN_HI = 2'd1,
      REG_VEC   = 2'd2,
      REG_RSVD  = 2'd3
   } intc_reg_e;

   localparam int INTC_ADDR_W = 2;

endpackage

// File: rtl/intc_enable_regs.sv
module intc_enable_regs #(
   parameter int NUM_SRC = 48,
   parameter int DATA_W  = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [intc_pkg::INTC_ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0]             wdata,
   output logic [NUM_SRC-1:0]            en_mask,
   output logic [DATA_W-1:0]             rd_lo,
   output logic [DATA_W-1:0]             rd_hi
);
   import intc_pkg::*;

   localparam int LO_W = (NUM_SRC > DATA_W) ? DATA_W : NUM_SRC;
   localparam int HI_W = NUM_SRC - LO_W;

   logic [LO_W-1:0] en_lo_q;
   logic            wr_lo;

   assign wr_lo = wr_en && (addr == REG_EN_LO);

   always_ff @(posedge clk) begin
      if (!rst_n)     en_lo_q <= '0;
      else if (wr_lo) en_lo_q <= wdata[LO_W-1:0];
   end

   always_comb begin
      rd_lo = '0;
      rd_lo[LO_W-1:0] = en_lo_q;
   end

   generate
      if (HI_W > 0) begin : g_hi
         logic [HI_W-1:0] en_hi_q;
         logic            wr_hi;
         assign wr_hi = wr_en && (addr == REG_EN_HI);
         always_ff @(posedge clk) begin
            if (!rst_n)     en_hi_q <= '0;
            else if (wr_hi) en_hi_q <= wdata[HI_W-1:0];
         end
         always_comb begin
            rd_hi = '0;
            rd_hi[HI_W-1:0] = en_hi_q;
         end
         assign en_mask = {en_hi_q, en_lo_q};
      end else begin : g_no_hi
         assign rd_hi   = '0;
         assign en_mask = en_lo_q;
      end
   endgenerate

   // enables only move on a write to one of the two enable addresses
   assert_en_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (addr == REG_EN_LO || addr == REG_EN_HI)) |=> $stable(en_mask));

   // writes to the vector or reserved address leave enables unchanged
   assert_no_side_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (addr == REG_VEC || addr == REG_RSVD)) |=> $stable(en_mask));

endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
   parameter int NUM_SRC = 48,
   parameter int GROUP_W = 8,
   parameter int IDX_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_masked,
   output logic               any_hit,
   output logic [IDX_W-1:0]   win_idx
);
   localparam int NUM_GRP = (NUM_SRC + GROUP_W - 1) / GROUP_W;
   localparam int PAD_W   = NUM_GRP * GROUP_W;
   localparam int LIDX_W  = $clog2(GROUP_W);
   localparam int GIDX_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

   logic [PAD_W-1:0]   req_pad;
   logic [NUM_GRP-1:0] grp_hit;
   logic [LIDX_W-1:0]  grp_idx [NUM_GRP];
   logic [GIDX_W-1:0]  win_grp;

   assign req_pad = PAD_W'(req_masked);

   // first level: highest set bit inside each group
   generate
      for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
         logic [GROUP_W-1:0] slice;
         logic [LIDX_W-1:0]  loc;
         assign slice = req_pad[g*GROUP_W +: GROUP_W];
         always_comb begin
            loc = '0;
            for (int b = 0; b < GROUP_W; b++) begin
               if (slice[b]) loc = LIDX_W'(b);
            end
         end
         assign grp_hit[g] = |slice;
         assign grp_idx[g] = loc;
      end
   endgenerate

   // second level: highest group with any request
   always_comb begin
      win_grp = '0;
      for (int g = 0; g < NUM_GRP; g++) begin
         if (grp_hit[g]) win_grp = GIDX_W'(g);
      end
   end

   assign any_hit = |grp_hit;
   assign win_idx = IDX_W'(int'(win_grp) * GROUP_W + int'(grp_idx[win_grp]));

   assert_winner_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
      any_hit |-> req_masked[win_idx]);

   assert_nothing_above_R1: assert property (@(posedge clk) disable iff (!rst_n)
      any_hit |-> (((req_masked >> win_idx) >> 1) == '0));

   assert_idle_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !any_hit |-> (req_masked == '0));

endmodule

// File: rtl/intc_vec_latch.sv
module intc_vec_latch #(
   parameter int         VEC_W    = 8,
   parameter logic [7:0] VEC_BASE = 8'h10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack_stb,
   input  logic [VEC_W-1:0] live_vec,
   output logic [VEC_W-1:0] vec_byte
);
   always_ff @(posedge clk) begin
      if (!rst_n)       vec_byte <= VEC_W'(VEC_BASE);
      else if (ack_stb) vec_byte <= live_vec;
   end

   assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ack_stb |=> (vec_byte == $past(live_vec)));

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_stb |=> $stable(vec_byte));

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
   parameter int         NUM_SRC   = 48,
   parameter int         DATA_W    = 32,
   parameter int         GROUP_W   = 8,
   parameter logic [7:0] VEC_BASE  = 8'h10,
   parameter bit         TIE_SRC0  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic               gie_a,
   input  logic               gie_b,
   input  logic               wr_en,
   input  logic [1:0]         addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   input  logic               ack_stb,
   output logic               cpu_irq,
   output logic [7:0]         vec_byte
);
   import intc_pkg::*;

   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int VEC_W = 8;

   generate
      if (NUM_SRC > 2 * DATA_W) begin : g_chk_words
         $error("NUM_SRC exceeds two enable words");
      end
      if (int'(VEC_BASE) + NUM_SRC > 256) begin : g_chk_vec
         $error("vector range exceeds one byte");
      end
      if (GROUP_W < 2 || (GROUP_W & (GROUP_W - 1)) != 0) begin : g_chk_grp
         $error("GROUP_W must be a power of two, at least 2");
      end
      if (DATA_W < VEC_W) begin : g_chk_data
         $error("DATA_W must hold the vector byte");
      end
   endgenerate

   logic [NUM_SRC-1:0] en_mask;
   logic [DATA_W-1:0]  rd_lo, rd_hi;
   logic [NUM_SRC-1:0] req_src;
   logic [NUM_SRC-1:0] req_masked;
   logic               any_hit;
   logic [IDX_W-1:0]   win_idx;
   logic [VEC_W-1:0]   live_vec;

   intc_enable_regs #(
      .NUM_SRC (NUM_SRC),
      .DATA_W  (DATA_W)
   ) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .en_mask (en_mask),
      .rd_lo   (rd_lo),
      .rd_hi   (rd_hi)
   );

   generate
      if (TIE_SRC0) begin : g_tie0
         always_comb begin
            req_src    = irq_in;
            req_src[0] = 1'b0;
         end
      end else begin : g_keep0
         assign req_src = irq_in;
      end
   endgenerate

   assign req_masked = req_src & en_mask;

   intc_prio_pick #(
      .NUM_SRC (NUM_SRC),
      .GROUP_W (GROUP_W),
      .IDX_W   (IDX_W)
   ) u_pick (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_masked (req_masked),
      .any_hit    (any_hit),
      .win_idx    (win_idx)
   );

   assign live_vec = any_hit ? (VEC_BASE + VEC_W'(win_idx)) : VEC_BASE;
   assign cpu_irq  = any_hit && gie_a && gie_b;

   intc_vec_latch #(
      .VEC_W    (VEC_W),
      .VEC_BASE (VEC_BASE)
   ) u_vec (
      .clk      (clk),
      .rst_n    (rst_n),
      .ack_stb  (ack_stb),
      .live_vec (live_vec),
      .vec_byte (vec_byte)
   );

   always_comb begin
      rdata = '0;
      case (addr)
         REG_EN_LO: rdata = rd_lo;
         REG_EN_HI: rdata = rd_hi;
         REG_VEC:   rdata[VEC_W-1:0] = live_vec;
         default:   rdata = '0;
      endcase
   end

   assert_irq_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> (gie_a && gie_b && (req_masked != '0)));

   assert_vec_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (live_vec >= VEC_BASE) && (int'(live_vec) < int'(VEC_BASE) + NUM_SRC));

   assert_src0_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (TIE_SRC0 && irq_in == NUM_SRC'(1)) |-> !cpu_irq);

   assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == REG_RSVD) |-> (rdata == '0));

endmodule

// File: tb/tb_prio_vec_intc.sv
module tb_prio_vec_intc;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [47:0] irq_in;
   logic        gie_a, gie_b;
   logic        wr_en;
   logic [1:0]  addr;
   logic [31:0] wdata;
   logic [31:0] rdata;
   logic        ack_stb;
   logic        cpu_irq;
   logic [7:0]  vec_byte;

   int total = 0;
   int bad   = 0;
   logic [47:0] en_model = '0;

   always #2 clk = ~clk;

   prio_vec_intc dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_in   (irq_in),
      .gie_a    (gie_a),
      .gie_b    (gie_b),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .rdata    (rdata),
      .ack_stb  (ack_stb),
      .cpu_irq  (cpu_irq),
      .vec_byte (vec_byte)
   );

   function automatic logic [7:0] model_vec(logic [47:0] r, logic [47:0] e);
      logic [47:0] m;
      logic [7:0]  v;
      m = r & e;
      v = 8'h10;
      for (int i = 1; i < 48; i++) if (m[i]) v = 8'h10 + 8'(i);
      return v;
   endfunction

   function automatic logic model_irq(logic [47:0] r, logic [47:0] e, logic a, logic b);
      logic [47:0] m;
      m = r & e;
      m[0] = 1'b0;
      return (m != '0) && a && b;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = 2'd2;
      if (a == 2'd0) en_model[31:0]  = d;
      if (a == 2'd1) en_model[47:32] = d[15:0];
   endtask

   task automatic check_live(string req);
      #1;
      addr = 2'd2;
      #0;
      check(req, rdata, {24'h0, model_vec(irq_in, en_model)});
      check(req, {31'h0, cpu_irq}, {31'h0, model_irq(irq_in, en_model, gie_a, gie_b)});
   endtask

   task automatic do_ack(string req);
      logic [7:0] exp;
      @(negedge clk);
      ack_stb = 1'b1;
      exp = model_vec(irq_in, en_model);
      @(negedge clk);
      ack_stb = 1'b0;
      check(req, {24'h0, vec_byte}, {24'h0, exp});
   endtask

   initial begin
      #(4 * 200000);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] held;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; irq_in = '0; gie_a = 1'b0; gie_b = 1'b0;
      wr_en = 1'b0; addr = 2'd0; wdata = '0; ack_stb = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state R3 R7
      addr = 2'd0; #1;
      check("R3 reset lo", rdata, 32'h0);
      addr = 2'd1; #1;
      check("R3 reset hi", rdata, 32'h0);
      check("R7 reset vec", {24'h0, vec_byte}, 32'h10);

      // R3: upper bits of high word ignore writes
      reg_write(2'd1, 32'hFFFF_FFFF);
      addr = 2'd1; #1;
      check("R3 hi width", rdata, 32'h0000_FFFF);
      reg_write(2'd0, 32'hFFFF_FFFF);
      addr = 2'd0; #1;
      check("R3 lo write", rdata, 32'hFFFF_FFFF);

      // R9: reserved read zero, writes to 2/3 change nothing
      reg_write(2'd3, 32'h0);
      reg_write(2'd2, 32'h0);
      addr = 2'd3; #1;
      check("R9 reserved", rdata, 32'h0);
      addr = 2'd0; #1;
      check("R9 no side write", rdata, 32'hFFFF_FFFF);

      // R1: top priority
      @(negedge clk);
      gie_a = 1'b1; gie_b = 1'b1;
      irq_in = 48'h8000_0000_0002;
      check_live("R1 top");
      check("R1 top vec", rdata, 32'h3F);

      // R6: source 0 alone does nothing
      @(negedge clk);
      irq_in = 48'h1;
      check_live("R6 src0");
      check("R6 no irq", {31'h0, cpu_irq}, 32'h0);
      do_ack("R6 ack src0");

      // R4: each global enable gates
      @(negedge clk);
      irq_in = 48'h0000_0010_0000; gie_a = 1'b0; gie_b = 1'b1;
      check_live("R4 gie_a low");
      @(negedge clk);
      gie_a = 1'b1; gie_b = 1'b0;
      check_live("R4 gie_b low");
      check("R5 vec ungated", rdata, 32'h24);

      // R2 R8: request dropped in the acknowledge cycle
      @(negedge clk);
      gie_b = 1'b1;
      irq_in = 48'h0000_0010_0000;
      check_live("R2 level high");
      @(negedge clk);
      irq_in = '0; ack_stb = 1'b1;
      @(negedge clk);
      ack_stb = 1'b0;
      check("R8 dropped", {24'h0, vec_byte}, 32'h10);
      check_live("R2 level low");

      // R7: hold between acks
      @(negedge clk);
      irq_in = 48'h0000_0000_0100;
      do_ack("R7 capture");
      held = vec_byte;
      @(negedge clk);
      irq_in = 48'h4000_0000_0000;
      @(negedge clk);
      check("R7 hold", {24'h0, vec_byte}, {24'h0, held});

      // R3: disabled source loses
      reg_write(2'd1, 32'h0000_3FFF);
      irq_in = 48'h4000_0000_0100;
      check_live("R3 mask");

      // random mix
      for (int it = 0; it < 400; it++) begin
         @(negedge clk);
         if (($urandom % 8) == 0) begin
            if ($urandom % 2) reg_write(2'd0, $urandom);
            else              reg_write(2'd1, $urandom);
         end
         irq_in = {16'($urandom & $urandom & $urandom), 32'($urandom & $urandom & $urandom)};
         if (($urandom % 10) == 0) irq_in = '0;
         gie_a = ($urandom % 4) != 0;
         gie_b = ($urandom % 4) != 0;
         check_live("R1 R5 random");
         if ((it % 4) == 0) do_ack("R7 random ack");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule